// File: doc/BRIEF.md
# Tap-Major Convolution Layer Engine

This block computes one two-dimensional convolution layer, with stride 1 and no padding, entirely from three on-chip memories. One memory holds the weights, one holds the input feature map and one holds the results. A host fills the weight and feature memories through plain write ports, sets the layer shape on the configuration inputs and pulses `start`. The engine then walks the whole computation. When it is finished it raises `done` for one cycle, and the host reads each result word back through a read port with one cycle of latency.

The loop nest puts the kernel tap on the outside. For each kernel position the engine sweeps every output pixel, and inside that every input channel and output channel pair. It multiplies one weight by one input sample and adds the product into the result memory with a read-modify-write. Until the last tap has been applied, the result memory therefore holds partial sums. The first contribution to any output word overwrites that word rather than adding to it, so no clearing pass is needed. The datapath is a two-stage pipeline after the issue stage. When two accumulations to the same word would overlap in that pipeline, the issue stage stalls until the earlier write has landed.

The layer shape is chosen at run time within fixed maxima. The shape inputs are the kernel size K, the output rows R, the output columns C, the input channel count and the output channel count. The input map is (R+K-1) rows by (C+K-1) columns. The shape inputs must stay stable while the engine is busy.

The control is a four-state machine:
- `ST_IDLE`: waiting for `start`.
- `ST_RUN`: issuing operations.
- `ST_DRAIN`: letting the pipeline empty.
- `ST_FINISH`: the one-cycle `done` state.

Its transitions are:
- launch: `ST_IDLE` to `ST_RUN`, taken on `start`.
- last issue: `ST_RUN` to `ST_DRAIN`, taken when the final loop index combination issues.
- drained: `ST_DRAIN` to `ST_FINISH`, taken when both pipeline stages are empty.
- retire: `ST_FINISH` to `ST_IDLE`, taken unconditionally.

Top module: `conv_engine`

## Requirements
- R1: A `start` pulse while idle launches a run. `busy` is high from the cycle after `start` is sampled until the cycle after `done`. `done` is high for exactly one cycle, after which `busy` is low.
- R2: After a run, every result word for output channel o, row r and column c holds the exact sum, over input channels i and kernel offsets (a,b), of W[o][i][a][b] × IN[i][r+a][c+b]. Stride is 1, there is no padding, and the input map is (R+K-1) × (C+K-1).
- R3: Memory layouts:
  - The weight word for (o,i,a,b) sits at address ((o×CI+i)×K+a)×K+b.
  - The input sample at channel i, row y, column x sits at (i×(R+K-1)+y)×(C+K-1)+x.
  - The result for (o,r,c) sits at (o×R+r)×C+c.
  - CI is the input channel count and K is the kernel size.
- R4: Operands are 16-bit two's complement. Results are ACC_W = 32 + clog2(MAX_CH×MAX_K²) bits wide (38 by default) and never wrap, even with every operand at -32768 and the largest shape.
- R5: The first contribution to each result word overwrites it. Values left in the result memory by an earlier run do not affect the new results.
- R6: Two writes to the same result address are always at least three cycles apart. As a result, a layer with one or two output channels still produces exact results even though consecutive operations target the same word.
- R7: When the output channel count exceeds 2, the engine issues one multiply-accumulate per cycle. `done` is then seen exactly N+4 cycles after the `start` sampling edge, with N = K²×R×C×CI×CO.
- R8: A `start` pulse while busy is ignored: the run length and the results are unchanged, and no second run follows.
- R9: A kernel size of 1 and an output channel count of 1 are legal shapes and give exact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| cfg_k | input | KW | Kernel size K, 1..MAX_K |
| cfg_rows | input | RW | Output rows R, 1..MAX_ROWS |
| cfg_cols | input | CW | Output columns C, 1..MAX_COLS |
| cfg_in_ch | input | HW | Input channel count, 1..MAX_CH |
| cfg_out_ch | input | HW | Output channel count, 1..MAX_CH |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle completion pulse |
| wt_wr_en | input | 1 | Weight memory write enable |
| wt_wr_addr | input | WAW | Weight memory write address |
| wt_wr_data | input | DATA_W | Weight word, signed |
| fm_wr_en | input | 1 | Input feature memory write enable |
| fm_wr_addr | input | FAW | Input feature memory write address |
| fm_wr_data | input | DATA_W | Input sample, signed |
| res_rd_addr | input | OAW | Result read address, used while idle |
| res_rd_data | output | ACC_W | Result word, one cycle after the address |

## Verification
The engine can go wrong in three internal places: a loop counter that wraps at the wrong limit, a stale partial sum caught by the read-modify-write, or a missed overwrite on the first contribution. Each of these shows up only in the result words once `done` has fired. The bench therefore compares every word of every run against a reference computed in the bench, using shapes with one and two output channels that force stalls, shapes with K=1, and back-to-back runs over the same memory. A control fault shows up sooner: a wrong next-state or stall decision moves `done` away from its exact cycle count or stretches it, and this is caught on the very run where it happens.

// File: rtl/conv_pkg.sv
package conv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_FINISH
    } eng_state_t;

    // Loop levels, outermost first
    localparam int NLEV   = 6;
    localparam int LV_KR  = 0;
    localparam int LV_KC  = 1;
    localparam int LV_ROW = 2;
    localparam int LV_COL = 3;
    localparam int LV_CHI = 4;
    localparam int LV_CHO = 5;

endpackage

// File: rtl/conv_ram.sv
module conv_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Registered read; a read colliding with a write returns the old word
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/conv_loop_level.sv
module conv_loop_level #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] idx,
    output logic         last
);

    assign last = (idx == limit - W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx <= '0;
        end else if (inc) begin
            idx <= last ? '0 : idx + W'(1);
        end
    end

endmodule

// File: rtl/conv_addr_gen.sv
module conv_addr_gen #(
    parameter int KW  = 2,
    parameter int RW  = 3,
    parameter int CW  = 3,
    parameter int HW  = 3,
    parameter int LW  = 3,
    parameter int WAW = 8,
    parameter int FAW = 8,
    parameter int OAW = 8
) (
    input  logic [KW-1:0]  cfg_k,
    input  logic [RW-1:0]  cfg_rows,
    input  logic [CW-1:0]  cfg_cols,
    input  logic [HW-1:0]  cfg_in_ch,
    input  logic [LW-1:0]  kr,
    input  logic [LW-1:0]  kc,
    input  logic [LW-1:0]  row,
    input  logic [LW-1:0]  col,
    input  logic [LW-1:0]  chi,
    input  logic [LW-1:0]  cho,
    output logic [WAW-1:0] wt_addr,
    output logic [FAW-1:0] fm_addr,
    output logic [OAW-1:0] res_addr
);

    logic [31:0] in_h;
    logic [31:0] in_w;

    always_comb begin
        in_h = 32'(cfg_rows) + 32'(cfg_k) - 32'd1;
        in_w = 32'(cfg_cols) + 32'(cfg_k) - 32'd1;

        // Weight order: out channel, in channel, kernel row, kernel column
        wt_addr = WAW'(((32'(cho) * 32'(cfg_in_ch) + 32'(chi)) * 32'(cfg_k)
                        + 32'(kr)) * 32'(cfg_k) + 32'(kc));

        // Input sample at row r+kr, column c+kc of channel chi
        fm_addr = FAW'((32'(chi) * in_h + 32'(row) + 32'(kr)) * in_w
                       + 32'(col) + 32'(kc));

        // Result order: out channel, row, column
        res_addr = OAW'((32'(cho) * 32'(cfg_rows) + 32'(row)) * 32'(cfg_cols)
                        + 32'(col));
    end

endmodule

// File: rtl/conv_engine.sv
module conv_engine
    import conv_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MAX_K    = 3,
    parameter int MAX_ROWS = 6,
    parameter int MAX_COLS = 6,
    parameter int MAX_CH   = 4,
    localparam int KW        = $clog2(MAX_K + 1),
    localparam int RW        = $clog2(MAX_ROWS + 1),
    localparam int CW        = $clog2(MAX_COLS + 1),
    localparam int HW        = $clog2(MAX_CH + 1),
    localparam int WT_DEPTH  = MAX_CH * MAX_CH * MAX_K * MAX_K,
    localparam int FM_DEPTH  = MAX_CH * (MAX_ROWS + MAX_K - 1) * (MAX_COLS + MAX_K - 1),
    localparam int RES_DEPTH = MAX_CH * MAX_ROWS * MAX_COLS,
    localparam int WAW       = $clog2(WT_DEPTH),
    localparam int FAW       = $clog2(FM_DEPTH),
    localparam int OAW       = $clog2(RES_DEPTH),
    localparam int ACC_W     = 2 * DATA_W + $clog2(MAX_CH * MAX_K * MAX_K)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KW-1:0]     cfg_k,
    input  logic [RW-1:0]     cfg_rows,
    input  logic [CW-1:0]     cfg_cols,
    input  logic [HW-1:0]     cfg_in_ch,
    input  logic [HW-1:0]     cfg_out_ch,
    output logic              busy,
    output logic              done,
    input  logic              wt_wr_en,
    input  logic [WAW-1:0]    wt_wr_addr,
    input  logic [DATA_W-1:0] wt_wr_data,
    input  logic              fm_wr_en,
    input  logic [FAW-1:0]    fm_wr_addr,
    input  logic [DATA_W-1:0] fm_wr_data,
    input  logic [OAW-1:0]    res_rd_addr,
    output logic [ACC_W-1:0]  res_rd_data
);

    localparam int MAX_RC = (MAX_ROWS > MAX_COLS) ? MAX_ROWS : MAX_COLS;
    localparam int MAX_KC = (MAX_K > MAX_CH) ? MAX_K : MAX_CH;
    localparam int MAXD   = (MAX_RC > MAX_KC) ? MAX_RC : MAX_KC;
    localparam int LW     = $clog2(MAXD + 1);
    localparam int PW     = 2 * DATA_W;

    eng_state_t state, state_nx;

    logic              launch;
    logic              step;
    logic              hazard;
    logic              last_issue;
    logic              first_contrib;

    logic [LW-1:0]     lim  [NLEV];
    logic [LW-1:0]     idx  [NLEV];
    logic [NLEV-1:0]   last;
    logic [NLEV-1:0]   inc;

    logic [WAW-1:0]    eng_wt_addr;
    logic [FAW-1:0]    eng_fm_addr;
    logic [OAW-1:0]    eng_res_addr;
    logic [OAW-1:0]    res_raddr;

    logic [DATA_W-1:0] w_q;
    logic [DATA_W-1:0] x_q;
    logic [ACC_W-1:0]  o_q;

    // Pipeline stage registers
    logic              s1_v;
    logic [OAW-1:0]    s1_addr;
    logic              s1_first;
    logic              s2_v;
    logic [OAW-1:0]    s2_addr;
    logic              s2_first;
    logic signed [PW-1:0]    s2_prod;
    logic signed [ACC_W-1:0] s2_old;

    logic signed [PW-1:0]    prod_c;
    logic signed [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0]        acc_sum;

    // ------------------------------------------------------------------
    // Loop nest: six counters, kernel tap outermost, output channel innermost
    // ------------------------------------------------------------------
    always_comb begin
        lim[LV_KR]  = LW'(cfg_k);
        lim[LV_KC]  = LW'(cfg_k);
        lim[LV_ROW] = LW'(cfg_rows);
        lim[LV_COL] = LW'(cfg_cols);
        lim[LV_CHI] = LW'(cfg_in_ch);
        lim[LV_CHO] = LW'(cfg_out_ch);
    end

    always_comb begin
        inc[NLEV-1] = step;
        for (int i = NLEV - 2; i >= 0; i--) begin
            inc[i] = inc[i+1] & last[i+1];
        end
    end

    for (genvar g = 0; g < NLEV; g++) begin : g_level
        conv_loop_level #(
            .W(LW)
        ) u_level (
            .clk  (clk),
            .rst_n(rst_n),
            .clear(launch),
            .inc  (inc[g]),
            .limit(lim[g]),
            .idx  (idx[g]),
            .last (last[g])
        );
    end

    conv_addr_gen #(
        .KW (KW),
        .RW (RW),
        .CW (CW),
        .HW (HW),
        .LW (LW),
        .WAW(WAW),
        .FAW(FAW),
        .OAW(OAW)
    ) u_addr (
        .cfg_k    (cfg_k),
        .cfg_rows (cfg_rows),
        .cfg_cols (cfg_cols),
        .cfg_in_ch(cfg_in_ch),
        .kr       (idx[LV_KR]),
        .kc       (idx[LV_KC]),
        .row      (idx[LV_ROW]),
        .col      (idx[LV_COL]),
        .chi      (idx[LV_CHI]),
        .cho      (idx[LV_CHO]),
        .wt_addr  (eng_wt_addr),
        .fm_addr  (eng_fm_addr),
        .res_addr (eng_res_addr)
    );

    // First contribution to a result word: tap (0,0) and input channel 0
    assign first_contrib = (idx[LV_KR] == '0) && (idx[LV_KC] == '0)
                        && (idx[LV_CHI] == '0);

    // Read-after-write guard against both stages still holding a write
    assign hazard = (s1_v && (s1_addr == eng_res_addr))
                 || (s2_v && (s2_addr == eng_res_addr));

    // ------------------------------------------------------------------
    // Control state machine
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)             state_nx = ST_RUN;
            ST_RUN:    if (last_issue)        state_nx = ST_DRAIN;
            ST_DRAIN:  if (!s1_v && !s2_v)    state_nx = ST_FINISH;
            ST_FINISH:                        state_nx = ST_IDLE;
            default:                          state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        launch     = 1'b0;
        step       = 1'b0;
        busy       = 1'b1;
        done       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy   = 1'b0;
                launch = start;
            end
            ST_RUN:    step = !hazard;
            ST_DRAIN:  ;
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
        last_issue = step && (&last);
    end

    // ------------------------------------------------------------------
    // Memories
    // ------------------------------------------------------------------
    conv_ram #(
        .DW   (DATA_W),
        .DEPTH(WT_DEPTH),
        .AW   (WAW)
    ) u_wt_ram (
        .clk  (clk),
        .we   (wt_wr_en),
        .waddr(wt_wr_addr),
        .wdata(wt_wr_data),
        .raddr(eng_wt_addr),
        .rdata(w_q)
    );

    conv_ram #(
        .DW   (DATA_W),
        .DEPTH(FM_DEPTH),
        .AW   (FAW)
    ) u_fm_ram (
        .clk  (clk),
        .we   (fm_wr_en),
        .waddr(fm_wr_addr),
        .wdata(fm_wr_data),
        .raddr(eng_fm_addr),
        .rdata(x_q)
    );

    assign res_raddr = busy ? eng_res_addr : res_rd_addr;

    conv_ram #(
        .DW   (ACC_W),
        .DEPTH(RES_DEPTH),
        .AW   (OAW)
    ) u_res_ram (
        .clk  (clk),
        .we   (s2_v),
        .waddr(s2_addr),
        .wdata(acc_sum),
        .raddr(res_raddr),
        .rdata(o_q)
    );

    assign res_rd_data = o_q;

    // ------------------------------------------------------------------
    // Multiply-accumulate pipeline
    // ------------------------------------------------------------------
    assign prod_c   = $signed(w_q) * $signed(x_q);
    assign prod_ext = {{(ACC_W - PW){s2_prod[PW-1]}}, s2_prod};
    assign acc_sum  = s2_first ? prod_ext : (s2_old + prod_ext);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_addr  <= '0;
            s1_first <= 1'b0;
            s2_v     <= 1'b0;
            s2_addr  <= '0;
            s2_first <= 1'b0;
            s2_prod  <= '0;
            s2_old   <= '0;
        end else begin
            s1_v     <= step;
            s1_addr  <= eng_res_addr;
            s1_first <= first_contrib;
            s2_v     <= s1_v;
            s2_addr  <= s1_addr;
            s2_first <= s1_first;
            s2_prod  <= prod_c;
            s2_old   <= $signed(o_q);
        end
    end

endmodule

// File: rtl/conv_engine_chk.sv
module conv_engine_chk #(
    parameter int OAW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           o_we,
    input logic [OAW-1:0] o_waddr
);

    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_idle_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_launch_by_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_write_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        o_we |-> busy);

    p_raw_gap1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (o_we && $past(o_we)) |-> (o_waddr != $past(o_waddr)));

    p_raw_gap2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (o_we && $past(o_we, 2)) |-> (o_waddr != $past(o_waddr, 2)));

endmodule

bind conv_engine conv_engine_chk #(
    .OAW(OAW)
) u_conv_engine_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .o_we   (s2_v),
    .o_waddr(s2_addr)
);

// File: tb/test_conv_engine.sv
module test_conv_engine;

    localparam int DATA_W   = 16;
    localparam int MAX_K    = 3;
    localparam int MAX_ROWS = 6;
    localparam int MAX_COLS = 6;
    localparam int MAX_CH   = 4;
    localparam int KW    = $clog2(MAX_K + 1);
    localparam int RW    = $clog2(MAX_ROWS + 1);
    localparam int CW    = $clog2(MAX_COLS + 1);
    localparam int HW    = $clog2(MAX_CH + 1);
    localparam int WAW   = $clog2(MAX_CH * MAX_CH * MAX_K * MAX_K);
    localparam int FAW   = $clog2(MAX_CH * (MAX_ROWS + MAX_K - 1) * (MAX_COLS + MAX_K - 1));
    localparam int OAW   = $clog2(MAX_CH * MAX_ROWS * MAX_COLS);
    localparam int ACC_W = 2 * DATA_W + $clog2(MAX_CH * MAX_K * MAX_K);

    typedef struct {
        longint value;
        string  tag;
        int     addr;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [KW-1:0]     cfg_k = '0;
    logic [RW-1:0]     cfg_rows = '0;
    logic [CW-1:0]     cfg_cols = '0;
    logic [HW-1:0]     cfg_in_ch = '0;
    logic [HW-1:0]     cfg_out_ch = '0;
    logic              busy;
    logic              done;
    logic              wt_wr_en = 1'b0;
    logic [WAW-1:0]    wt_wr_addr = '0;
    logic [DATA_W-1:0] wt_wr_data = '0;
    logic              fm_wr_en = 1'b0;
    logic [FAW-1:0]    fm_wr_addr = '0;
    logic [DATA_W-1:0] fm_wr_data = '0;
    logic [OAW-1:0]    res_rd_addr = '0;
    logic [ACC_W-1:0]  res_rd_data;

    logic rd_req = 1'b0;
    logic rd_tag = 1'b0;

    int checks = 0;
    int errors = 0;
    exp_item_t exp_q[$];
    int wmem [MAX_CH * MAX_CH * MAX_K * MAX_K];
    int xmem [MAX_CH * (MAX_ROWS + MAX_K - 1) * (MAX_COLS + MAX_K - 1)];

    always #2 clk = ~clk;

    conv_engine i_conv_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_k      (cfg_k),
        .cfg_rows   (cfg_rows),
        .cfg_cols   (cfg_cols),
        .cfg_in_ch  (cfg_in_ch),
        .cfg_out_ch (cfg_out_ch),
        .busy       (busy),
        .done       (done),
        .wt_wr_en   (wt_wr_en),
        .wt_wr_addr (wt_wr_addr),
        .wt_wr_data (wt_wr_data),
        .fm_wr_en   (fm_wr_en),
        .fm_wr_addr (fm_wr_addr),
        .fm_wr_data (fm_wr_data),
        .res_rd_addr(res_rd_addr),
        .res_rd_data(res_rd_data)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard as read data comes back
    always @(posedge clk) rd_tag <= rd_req;

    always @(negedge clk) begin
        if (rd_tag) begin
            exp_item_t it;
            longint act;
            it  = exp_q.pop_front();
            act = longint'($signed(res_rd_data));
            check(act == it.value, it.tag, act, it.value);
        end
    end

    // mode 0: random operands, 1: all operands at -32768
    task automatic run_shape(input int k, input int r, input int c, input int ci,
                             input int co, input int mode, input bit poke, input string tag);
        int ih;
        int iw;
        int n;
        int cnt;
        ih = r + k - 1;
        iw = c + k - 1;
        n  = k * k * r * c * ci * co;

        // Load weights (R3 layout)
        for (int a = 0; a < co * ci * k * k; a++) begin
            wmem[a] = (mode == 1) ? -32768 : int'($urandom_range(600)) - 300;
            @(negedge clk);
            wt_wr_en   = 1'b1;
            wt_wr_addr = WAW'(a);
            wt_wr_data = DATA_W'(wmem[a]);
        end
        for (int a = 0; a < ci * ih * iw; a++) begin
            xmem[a] = (mode == 1) ? -32768 : int'($urandom_range(600)) - 300;
            @(negedge clk);
            wt_wr_en   = 1'b0;
            fm_wr_en   = 1'b1;
            fm_wr_addr = FAW'(a);
            fm_wr_data = DATA_W'(xmem[a]);
        end
        @(negedge clk);
        wt_wr_en   = 1'b0;
        fm_wr_en   = 1'b0;
        cfg_k      = KW'(k);
        cfg_rows   = RW'(r);
        cfg_cols   = CW'(c);
        cfg_in_ch  = HW'(ci);
        cfg_out_ch = HW'(co);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt   = 1;
        check(busy == 1'b1, {"R1 busy after start ", tag}, longint'(busy), 1);
        while (!done && cnt < 20000) begin
            @(negedge clk);
            cnt++;
            if (poke && cnt == 3) start = 1'b1;
            if (poke && cnt == 4) start = 1'b0;
        end
        start = 1'b0;
        if (co > 2) begin
            check(cnt == n + 4, {"R7 cycles to done ", tag}, cnt, n + 4);
        end else begin
            check(cnt >= n + 4 && cnt < 20000, {"R6 stalled run completes ", tag}, cnt, n + 4);
        end
        @(negedge clk);
        check(done == 1'b0, {"R1 done one cycle ", tag}, longint'(done), 0);
        check(busy == 1'b0, {"R1 busy low after done ", tag}, longint'(busy), 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            check(busy == 1'b0, {"R8 no relaunch ", tag}, longint'(busy), 0);
        end

        // Driver: push expected words and request reads (R2, R3 layout)
        for (int o = 0; o < co; o++) begin
            for (int y = 0; y < r; y++) begin
                for (int x = 0; x < c; x++) begin
                    exp_item_t it;
                    longint sum;
                    sum = 0;
                    for (int i = 0; i < ci; i++)
                        for (int a = 0; a < k; a++)
                            for (int b = 0; b < k; b++)
                                sum += longint'(wmem[((o * ci + i) * k + a) * k + b])
                                     * longint'(xmem[(i * ih + y + a) * iw + x + b]);
                    it.value = sum;
                    it.addr  = (o * r + y) * c + x;
                    it.tag   = {"R2 result ", tag};
                    exp_q.push_back(it);
                    rd_req      = 1'b1;
                    res_rd_addr = OAW'(it.addr);
                    @(negedge clk);
                end
            end
        end
        rd_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                check(busy == 1'b0, "R1 reset busy", longint'(busy), 0);
                check(done == 1'b0, "R1 reset done", longint'(done), 0);
                rst_n = 1'b1;
                @(negedge clk);
                run_shape(3, 4, 5, 2, 4, 0, 1'b0, "R7 full rate K3");
                run_shape(1, 3, 3, 3, 1, 0, 1'b0, "R9 K1 CO1");
                run_shape(3, 3, 4, 4, 2, 0, 1'b0, "R6 CO2 stall");
                run_shape(2, 2, 2, 1, 1, 0, 1'b0, "R6 R9 CI1 CO1");
                run_shape(3, 6, 6, 4, 4, 1, 1'b0, "R4 extreme");
                run_shape(3, 6, 6, 4, 4, 0, 1'b0, "R5 stale memory");
                run_shape(2, 5, 3, 3, 3, 0, 1'b1, "R8 start while busy");
                run_shape(1, 6, 6, 4, 3, 0, 1'b0, "R3 K1 wide");
                for (int t = 0; t < 3; t++) begin
                    run_shape(int'($urandom_range(2)) + 1, int'($urandom_range(5)) + 1,
                              int'($urandom_range(5)) + 1, int'($urandom_range(3)) + 1,
                              int'($urandom_range(3)) + 1, 0, 1'b0, "R2 random");
                end
                check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog R1: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule